// File: doc/BRIEF.md
# Serial UART Core with 9th-Bit Addressing and Internal Loopback

This block sends and receives asynchronous serial characters. A character is one start bit, a parameterised number of data bits sent least significant bit first, an optional ninth (parity) bit and one stop bit. The bit rate comes from a fixed clocks-per-bit parameter. Three small registers set the parity, select the line options and give access to the modem handshake lines. They are reached through a plain write/read port with a two-bit address.

There are three line options. The serial lines can be inverted. An addressing mode lets the ninth bit tell address characters apart from data characters on a shared bus. A self-test path joins the transmitter to the receiver inside the block, and it also routes the handshake lines internally. A host loads a character with a one-cycle write strobe whenever the busy flag is low. Each received character appears for one cycle on a valid strobe, together with an address flag and error flags.

Top module: `uart_md`

## Requirements
- R1: The line idles at 1 (before inversion). A frame is a start bit 0, then the data bits LSB first, then the parity bit if enabled, then a stop bit 1. Every bit lasts CLKS_PER_BIT clocks.
- R2: Line-control register (address 0) bit 0 enables parity and bit 1 selects it. With addressing mode off and parity on, select 1 gives even parity and select 0 gives odd parity. With parity off, no ninth bit is sent.
- R3: With addressing mode on and parity on, the ninth bit is forced to the select bit: 1 gives mark and 0 gives space.
- R4: In addressing mode, a character sent with mark parity clears the select bit to 0 when it reaches its stop bit, so later characters go out with space parity. A write to the select bit while a character is being sent affects only the next character.
- R5: Modem-control register (address 1) bit 6 inverts both the transmit pin and the receive pin.
- R6: Modem-control bit 4 enables loopback. In loopback the transmit pin is held at 1, the receiver takes the internal transmit stream, and the receive pin is ignored.
- R7: Modem-control bits 3:0 are handshake bits, and bits 3:2 drive the two auxiliary outputs. In loopback both outputs are 0 and the status register (address 2, bits 3:0) reads modem-control bits 3:0 instead of the status pins.
- R8: All register bits reset to 0. Modem-control bit 5 enables addressing mode. Bit 7 of modem control always reads 0 and cannot be written.
- R9: tx_busy is high while a frame is being sent. A tx_we pulse while busy is ignored.
- R10: The receiver pulses rx_valid for one cycle with the received data. rx_par_err flags a parity mismatch when addressing mode is off, and rx_frm_err flags a stop bit of 0.
- R11: In addressing mode with parity on, rx_addr_flag carries the received ninth bit and rx_par_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 line, 1 modem, 2 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_we | input | 1 | Load a character for sending |
| tx_data | input | DATA_W | Character to send |
| tx_busy | output | 1 | Transmitter is sending a frame |
| rx_valid | output | 1 | One-cycle received-character strobe |
| rx_data | output | DATA_W | Received character |
| rx_addr_flag | output | 1 | Received ninth bit in addressing mode |
| rx_par_err | output | 1 | Parity mismatch |
| rx_frm_err | output | 1 | Stop bit was 0 |
| txd_pin | output | 1 | Serial transmit pin |
| rxd_pin | input | 1 | Serial receive pin |
| mdm_stat_in | input | 4 | Modem status inputs |
| mdm_aux_out | output | 2 | Auxiliary modem control outputs |

## Verification
The hardest case to reach is the interaction between the self-clearing select bit and a write to that bit during a character. The select bit must be rewritten partway through a frame, and the bench must then observe which parity each of two consecutive characters used. The bench reaches this in loopback with addressing mode on. It starts a space-parity character, writes mark select in the middle of the frame, and reads the address flag the receiver reports for that character and the next. It also reads back the select bit after each character.

// File: rtl/uart_md_pkg.sv
package uart_md_pkg;
   // register addresses
   localparam logic [1:0] ADDR_LINE = 2'd0;
   localparam logic [1:0] ADDR_MDM  = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   typedef struct packed {
      logic par_sel;
      logic par_en;
   } line_ctl_t;

   typedef struct packed {
      logic       inv;
      logic       mdrop;
      logic       loop;
      logic [3:0] hs;
   } mdm_ctl_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
endpackage

// File: rtl/uart_md_regs.sv
module uart_md_regs
   import uart_md_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       mark_sent,
   input  logic [3:0] stat_pins,
   output line_ctl_t  lctl,
   output mdm_ctl_t   mctl
);
   logic [3:0] stat_eff;
   logic       wr_line;

   assign wr_line  = we && (addr == ADDR_LINE);
   assign stat_eff = mctl.loop ? mctl.hs : stat_pins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctl <= '0;
         mctl <= '0;
      end else begin
         if (mark_sent && mctl.mdrop) lctl.par_sel <= 1'b0;
         if (wr_line) lctl <= '{par_sel: wdata[1], par_en: wdata[0]};
         if (we && (addr == ADDR_MDM))
            mctl <= '{inv: wdata[6], mdrop: wdata[5], loop: wdata[4], hs: wdata[3:0]};
      end
   end

   always_comb begin
      case (addr)
         ADDR_LINE: rdata = {6'd0, lctl.par_sel, lctl.par_en};
         ADDR_MDM:  rdata = {1'b0, mctl};
         ADDR_STAT: rdata = {4'd0, stat_eff};
         default:   rdata = 8'd0;
      endcase
   end

   // R4
   sel_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_sent && mctl.mdrop && !wr_line) |=> !lctl.par_sel);
endmodule

// File: rtl/uart_md_tx.sv
module uart_md_tx #(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic              par_en,
   input  logic              forced,
   input  logic              par_sel,
   output logic              busy,
   output logic              ser,
   output logic              mark_sent
);
   localparam int FW = DATA_W + 3;
   localparam int IW = $clog2(FW + 1);
   localparam int CW = $clog2(CLKS_PER_BIT);

   logic [FW-1:0] frame;
   logic [IW-1:0] nleft;
   logic [CW-1:0] cnt;
   logic          cur_mark;
   logic          pbit;
   logic          bit_end;

   always_comb begin
      if (forced) pbit = par_sel;
      else        pbit = par_sel ? (^data) : ~(^data);
   end

   assign bit_end   = (cnt == CW'(CLKS_PER_BIT - 1));
   assign busy      = (nleft != '0);
   assign ser       = frame[0];
   assign mark_sent = busy && bit_end && (nleft == IW'(2)) && cur_mark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame    <= '1;
         nleft    <= '0;
         cnt      <= '0;
         cur_mark <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            frame    <= {1'b1, par_en ? pbit : 1'b1, data, 1'b0};
            nleft    <= par_en ? IW'(FW) : IW'(FW - 1);
            cnt      <= '0;
            cur_mark <= par_en && forced && par_sel;
         end
      end else if (bit_end) begin
         cnt   <= '0;
         frame <= {1'b1, frame[FW-1:1]};
         nleft <= nleft - IW'(1);
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   // R1
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !ser);
   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(bit_end && nleft == IW'(1))) |=> busy);
endmodule

// File: rtl/uart_md_rx.sv
module uart_md_rx
   import uart_md_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line,
   input  logic              par_en,
   input  logic              mdrop,
   input  logic              par_sel,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              addr_flag,
   output logic              par_err,
   output logic              frm_err
);
   localparam int CW   = $clog2(CLKS_PER_BIT);
   localparam int IW   = $clog2(DATA_W + 2);
   localparam int HALF = CLKS_PER_BIT / 2;

   rx_state_t     st;
   logic [CW-1:0] cnt;
   logic [IW-1:0] idx;
   logic [IW-1:0] npay;
   logic [DATA_W:0] sh;

   assign npay = par_en ? IW'(DATA_W + 1) : IW'(DATA_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0;
         valid <= 1'b0; data <= '0; addr_flag <= 1'b0;
         par_err <= 1'b0; frm_err <= 1'b0;
      end else begin
         valid <= 1'b0;
         case (st)
            RX_IDLE: if (!line) begin
               st <= RX_START; cnt <= '0;
            end
            RX_START: if (cnt == CW'(HALF - 1)) begin
               cnt <= '0; idx <= '0; sh <= '0;
               st  <= line ? RX_IDLE : RX_BITS;
            end else cnt <= cnt + CW'(1);
            RX_BITS: if (cnt == CW'(CLKS_PER_BIT - 1)) begin
               cnt <= '0;
               if (idx < npay) begin
                  sh[idx] <= line;
                  idx     <= idx + IW'(1);
               end else begin
                  st        <= RX_IDLE;
                  valid     <= 1'b1;
                  data      <= sh[DATA_W-1:0];
                  addr_flag <= par_en && mdrop && sh[DATA_W];
                  par_err   <= par_en && !mdrop && ((^sh) == par_sel);
                  frm_err   <= !line;
               end
            end else cnt <= cnt + CW'(1);
            default: st <= RX_IDLE;
         endcase
      end
   end

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R11
   mdrop_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mdrop) |-> !par_err);
endmodule

// File: rtl/uart_md.sv
module uart_md
   import uart_md_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              tx_we,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_addr_flag,
   output logic              rx_par_err,
   output logic              rx_frm_err,
   output logic              txd_pin,
   input  logic              rxd_pin,
   input  logic [3:0]        mdm_stat_in,
   output logic [1:0]        mdm_aux_out
);
   if (CLKS_PER_BIT < 4) begin : g_bad_cpb
      $error("CLKS_PER_BIT must be at least 4");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_dw
      $error("DATA_W must be 5..9");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..4");
   end

   line_ctl_t lctl;
   mdm_ctl_t  mctl;
   logic      tx_ser;
   logic      mark_sent;
   logic      rx_raw;
   logic      rx_line;

   uart_md_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .mark_sent(mark_sent),
      .stat_pins(mdm_stat_in), .lctl(lctl), .mctl(mctl)
   );

   uart_md_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_we), .data(tx_data),
      .par_en(lctl.par_en), .forced(mctl.mdrop), .par_sel(lctl.par_sel),
      .busy(tx_busy), .ser(tx_ser), .mark_sent(mark_sent)
   );

   assign txd_pin     = mctl.loop ? 1'b1 : (tx_ser ^ mctl.inv);
   assign mdm_aux_out = mctl.loop ? 2'b00 : mctl.hs[3:2];
   assign rx_raw      = mctl.loop ? tx_ser : (rxd_pin ^ mctl.inv);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_line = rx_raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], rx_raw};
      end
      assign rx_line = chain[SYNC_STAGES-1];
   end

   uart_md_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .line(rx_line), .par_en(lctl.par_en),
      .mdrop(mctl.mdrop), .par_sel(lctl.par_sel), .valid(rx_valid),
      .data(rx_data), .addr_flag(rx_addr_flag), .par_err(rx_par_err),
      .frm_err(rx_frm_err)
   );

   // R7
   loop_aux_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_MDM && reg_wdata[4]) |=> (mdm_aux_out == 2'b00));
endmodule

// File: tb/uart_md_test.sv
`timescale 1ns/1ps
module uart_md_test;
   localparam int CPB = 8;

   typedef struct packed {
      logic [7:0] d;
      logic [7:0] lc;
      logic [7:0] mc;
      logic [1:0] ep;   // expected ninth bit: 0, 1, or 2 = absent
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{d: 8'h55, lc: 8'h03, mc: 8'h00, ep: 2'd0},   // R2 even
      '{d: 8'h55, lc: 8'h01, mc: 8'h00, ep: 2'd1},   // R2 odd
      '{d: 8'h07, lc: 8'h03, mc: 8'h00, ep: 2'd1},   // R2 even
      '{d: 8'h07, lc: 8'h01, mc: 8'h00, ep: 2'd0},   // R2 odd
      '{d: 8'hA3, lc: 8'h00, mc: 8'h00, ep: 2'd2},   // R2 none
      '{d: 8'h07, lc: 8'h03, mc: 8'h20, ep: 2'd1},   // R3 mark
      '{d: 8'h07, lc: 8'h01, mc: 8'h20, ep: 2'd0},   // R3 space
      '{d: 8'h55, lc: 8'h03, mc: 8'h40, ep: 2'd0}    // R5 inverted
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       tx_we = 1'b0;
   logic [7:0] tx_data = 8'd0;
   logic       tx_busy, rx_valid, rx_addr_flag, rx_par_err, rx_frm_err, txd_pin;
   logic [7:0] rx_data;
   logic       rxd_pin = 1'b1;
   logic [3:0] mdm_stat_in = 4'd0;
   logic [1:0] mdm_aux_out;

   int checks = 0, fails = 0, rx_cnt = 0, txlow = 0;
   logic [7:0] got_d;
   logic got_af, got_pe, got_fe, loop_watch = 1'b0, done = 1'b0;

   always #2.5 clk = ~clk;

   uart_md #(.CLKS_PER_BIT(CPB), .DATA_W(8), .SYNC_STAGES(2)) uut (.*);

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt++; got_d = rx_data; got_af = rx_addr_flag;
         got_pe = rx_par_err; got_fe = rx_frm_err;
      end
      if (loop_watch && !txd_pin) txlow++;
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic capture_tx(input logic [7:0] d, input int nb, output logic [10:0] fr);
      fr = '1;
      @(negedge clk); tx_data = d; tx_we = 1'b1;
      @(posedge clk); #1 tx_we = 1'b0;
      for (int b = 0; b < nb; b++) begin
         repeat (b == 0 ? CPB / 2 : CPB) @(posedge clk);
         #1 fr[b] = txd_pin;
      end
      while (tx_busy) @(negedge clk);
   endtask

   task automatic tx_start(input logic [7:0] d);
      @(negedge clk); tx_data = d; tx_we = 1'b1;
      @(negedge clk); tx_we = 1'b0;
   endtask

   task automatic wait_rx(input int prev);
      int n = 0;
      while (rx_cnt == prev && n < 3000) begin @(negedge clk); n++; end
   endtask

   task automatic drive_rx(input logic [10:0] fr, input int nb, input logic inv);
      for (int b = 0; b < nb; b++) begin
         @(negedge clk); rxd_pin = fr[b] ^ inv;
         repeat (CPB - 1) @(negedge clk);
      end
      @(negedge clk); rxd_pin = ~inv;
   endtask

   function automatic logic [10:0] mkframe(input logic [7:0] d, input logic [1:0] ep);
      if (ep == 2'd2) return {2'b11, d, 1'b0};
      return {1'b1, ep[0], d, 1'b0};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [10:0] fr, ef;
      int nb, pc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state, R1 idle line, R9 not busy
      rreg(2'd0, r); chk(r == 8'h00, "R8 line reset", r, 0);
      rreg(2'd1, r); chk(r == 8'h00, "R8 modem reset", r, 0);
      chk(txd_pin == 1'b1 && !tx_busy, "R1 idle after reset", {tx_busy, txd_pin}, 1);
      chk(mdm_aux_out == 2'b00, "R7 aux reset", mdm_aux_out, 0);

      // table of transmit vectors: R1 R2 R3 R5
      foreach (VECS[i]) begin
         if (VECS[i].mc[6]) rxd_pin = 1'b0;
         wreg(2'd1, VECS[i].mc);
         wreg(2'd0, VECS[i].lc);
         nb = (VECS[i].ep == 2'd2) ? 10 : 11;
         capture_tx(VECS[i].d, nb, fr);
         ef = mkframe(VECS[i].d, VECS[i].ep);
         if (VECS[i].mc[6]) ef = ~ef;
         if (nb == 10) begin fr[10] = 1'b0; ef[10] = 1'b0; end
         chk(fr == ef, "R1/R2/R3/R5 frame", fr, ef);
         wreg(2'd1, 8'h00);
         rxd_pin = 1'b1;
      end

      // R8 bit 7 read-only
      wreg(2'd1, 8'hEF); rreg(2'd1, r);
      chk(r == 8'h6F, "R8 reserved bit", r, 8'h6F);
      // R7 aux outputs and status pins, no loopback
      wreg(2'd1, 8'h0C); mdm_stat_in = 4'hA;
      rreg(2'd2, r);
      chk(r == 8'h0A && mdm_aux_out == 2'b11, "R7 normal modem", {r, 6'd0, mdm_aux_out}, 16'h0A03);
      // R7 loopback reroutes status, aux idle
      wreg(2'd1, 8'h1C); rreg(2'd2, r);
      chk(r == 8'h0C && mdm_aux_out == 2'b00, "R7 loop modem", {r, 6'd0, mdm_aux_out}, 16'h0C00);
      wreg(2'd1, 8'h13); rreg(2'd2, r);
      chk(r == 8'h03, "R7 loop status", r, 3);

      // R4 self-clear after mark char
      wreg(2'd1, 8'h20); wreg(2'd0, 8'h03);
      capture_tx(8'h07, 11, fr);
      rreg(2'd0, r); chk(r == 8'h01, "R4 select cleared", r, 1);
      capture_tx(8'h07, 11, fr);
      chk(fr[9] == 1'b0, "R4 following char space", fr[9], 0);

      // R6 loopback: pin held high, rxd_pin ignored
      rxd_pin = 1'b0;
      wreg(2'd0, 8'h03); wreg(2'd1, 8'h10);
      loop_watch = 1'b1;
      pc = rx_cnt; tx_start(8'hC6); wait_rx(pc);
      chk(rx_cnt == pc + 1 && got_d == 8'hC6 && !got_pe, "R6 loop data", got_d, 8'hC6);
      // R9 write during busy ignored
      pc = rx_cnt; tx_start(8'h5A);
      repeat (3) @(negedge clk);
      tx_data = 8'hFF; tx_we = 1'b1; @(negedge clk); tx_we = 1'b0;
      wait_rx(pc);
      repeat (14 * CPB) @(negedge clk);
      chk(rx_cnt == pc + 1 && got_d == 8'h5A, "R9 busy write ignored", {rx_cnt - pc, got_d}, {32'd1, 8'h5A});

      // R4 write in flight, R11 address flag, in loopback
      wreg(2'd1, 8'h30); wreg(2'd0, 8'h01);
      pc = rx_cnt; tx_start(8'h3C);
      repeat (4 * CPB) @(negedge clk);
      wreg(2'd0, 8'h03);
      wait_rx(pc);
      chk(got_af == 1'b0 && !got_pe, "R4 in-flight write deferred", got_af, 0);
      while (tx_busy) @(negedge clk);
      rreg(2'd0, r); chk(r == 8'h03, "R4 select survives space char", r, 3);
      pc = rx_cnt; tx_start(8'h3C); wait_rx(pc);
      chk(got_af == 1'b1 && !got_pe, "R11 address flag", {got_af, got_pe}, 2);
      while (tx_busy) @(negedge clk);
      rreg(2'd0, r); chk(r == 8'h01, "R4 cleared after mark", r, 1);
      loop_watch = 1'b0;
      chk(txlow == 0, "R6 pin held high", txlow, 0);
      rxd_pin = 1'b1;
      wreg(2'd1, 8'h00);
      repeat (4 * CPB) @(negedge clk);

      // R10 receive: good, parity error, framing error
      wreg(2'd0, 8'h03);
      pc = rx_cnt; drive_rx(mkframe(8'h96, 2'd0), 11, 1'b0); wait_rx(pc);
      chk(got_d == 8'h96 && !got_pe && !got_fe, "R10 good char", {got_d, got_pe, got_fe}, {8'h96, 2'b00});
      pc = rx_cnt; drive_rx(mkframe(8'h96, 2'd1), 11, 1'b0); wait_rx(pc);
      chk(got_pe == 1'b1, "R10 parity error", got_pe, 1);
      fr = mkframe(8'h96, 2'd0); fr[10] = 1'b0;
      pc = rx_cnt; drive_rx(fr, 11, 1'b0); wait_rx(pc);
      chk(got_fe == 1'b1, "R10 framing error", got_fe, 1);
      repeat (12 * CPB) @(negedge clk);
      // R11 addressing mode, ninth bit 1, no parity error
      wreg(2'd1, 8'h20);
      pc = rx_cnt; drive_rx(mkframe(8'h96, 2'd1), 11, 1'b0); wait_rx(pc);
      chk(got_af && !got_pe && got_d == 8'h96, "R11 rx address", {got_af, got_pe}, 2);
      // R5 inverted receive
      rxd_pin = 1'b0; wreg(2'd1, 8'h40); wreg(2'd0, 8'h00);
      repeat (4 * CPB) @(negedge clk);
      pc = rx_cnt; drive_rx(mkframe(8'h2B, 2'd2), 10, 1'b1); wait_rx(pc);
      chk(got_d == 8'h2B && !got_fe, "R5 inverted rx", got_d, 8'h2B);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule